// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

The block picks a bundle of instructions to send to execution from six ready lists: integer, floating point, branch, memory, miscellaneous and a list of already-cancelled (squashed) instructions. Each list shows only its oldest entry, with a valid bit, a sequence number, a cancelled flag and a tag, and it advances when the block pulses that list's pop line. A pulse on `start_i` opens an issue round.

In each cycle of a round the block does one of three things. It discards one cancelled head, or it issues the oldest eligible head into the next bundle slot, or it closes the round. A list is eligible while it has an entry and its class has not reached its own per-round cap. Misc and squashed entries are limited only by the total issue width. A smaller sequence number always means older; there is no wraparound.

The controller has three states: `S_IDLE`, `S_PICK` and `S_DONE`. The transitions are:
- `S_IDLE`→`S_PICK` on `start_i`.
- `S_PICK`→`S_PICK` after a discard, or after an issue that leaves room in the bundle.
- `S_PICK`→`S_DONE` when the last slot fills or no list is eligible.
- `S_DONE`→`S_IDLE` unconditionally.

The bundle and the counts stay registered until the next round begins.

Top module: `issue_age_arbiter`

## Requirements
- R1: After reset the block is idle. `busy_o`, `done_o`, `pop_o`, `bundle_cnt_o`, `freed_o` and every class count are zero.
- R2: A `start_i` pulse while idle sets `busy_o` from the next cycle. The round ends with `done_o` high for exactly one cycle, and `busy_o` is low the cycle after.
- R3: Each issue takes the eligible head with the smallest sequence number. It writes that head's tag and class code into slot number `bundle_cnt_o`, then increments `bundle_cnt_o`. The class codes are integer 0, float 1, branch 2, memory 3, misc 4, squashed 5, and they are also the list indices.
- R4: When sequence numbers are equal, the lower class code wins.
- R5: Per round, at most INT_CAP integer, FP_CAP float, BR_CAP branch and MEM_CAP memory instructions issue. A class that reaches its cap stops being eligible for the rest of the round.
- R6: A round never issues more than ISSUE_W instructions, and it ends as soon as ISSUE_W have issued. Misc and squashed entries are bounded only by this limit.
- R7: An eligible head in lists 0 to 4 with its cancelled flag set is popped without issuing and uses no slot. When several such heads exist, the lowest list index is dropped first, and dropping takes priority over issuing. The cancelled flag on list 5 is ignored: its heads issue normally.
- R8: A round ends when no list is eligible. At `done_o`, `cls_cnt_o` holds the number of issues per class, and `freed_o` equals the number issued.
- R9: At most one pop is raised per cycle, and never to a list whose head is not valid.
- R10: `start_i` has no effect while a round is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens an issue round when idle |
| head_vld_i | input | 6 | Per-list head present |
| head_seq_i | input | 6×SEQ_W | Per-list head sequence number |
| head_sq_i | input | 6 | Per-list head cancelled flag |
| head_tag_i | input | 6×TAG_W | Per-list head tag |
| pop_o | output | 6 | Per-list advance pulse |
| busy_o | output | 1 | Round in progress |
| done_o | output | 1 | Round finished, bundle valid |
| bundle_tag_o | output | ISSUE_W×TAG_W | Issued tags by slot |
| bundle_cls_o | output | ISSUE_W×3 | Issued class code by slot |
| bundle_cnt_o | output | CNT_W | Number of filled slots |
| cls_cnt_o | output | 6×CNT_W | Issues per class this round |
| freed_o | output | CNT_W | Queue entries released this round |

## Verification
Suppose a per-class counter fails to clear or steps wrongly. A cap then trips early or late, and the difference shows in `cls_cnt_o` and the bundle contents when `done_o` rises. The same fault also shows in the head the list is left pointing at, because the pops are tracked against a model of the lists.

A wrong state transition shows up in other ways. It can make `done_o` last more than one cycle or never arrive. It can also raise a pop outside a round, or restart the counts while `start_i` is held. These faults appear within a few cycles of the start pulse.

A cancelled head that is issued instead of dropped shifts every later slot by one position.

// File: rtl/iss_pkg.sv
package iss_pkg;
    localparam int NCLS = 6;

    typedef enum logic [2:0] {
        C_INT  = 3'd0,
        C_FP   = 3'd1,
        C_BR   = 3'd2,
        C_MEM  = 3'd3,
        C_MISC = 3'd4,
        C_SQ   = 3'd5
    } cls_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PICK = 2'd1,
        S_DONE = 2'd2
    } st_e;
endpackage

// File: rtl/iss_elig.sv
module iss_elig
    import iss_pkg::*;
#(
    parameter int ISSUE_W = 4,
    parameter int INT_CAP = 2,
    parameter int FP_CAP  = 1,
    parameter int BR_CAP  = 1,
    parameter int MEM_CAP = 2,
    parameter int CNT_W   = $clog2(ISSUE_W + 1)
) (
    input  logic [NCLS-1:0]            vld,
    input  logic [NCLS-1:0][CNT_W-1:0] cnt,
    output logic [NCLS-1:0]            elig
);
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        localparam int CAP = (c == 0) ? INT_CAP :
                             (c == 1) ? FP_CAP  :
                             (c == 2) ? BR_CAP  :
                             (c == 3) ? MEM_CAP : ISSUE_W;
        assign elig[c] = vld[c] && (cnt[c] < CNT_W'(CAP));
    end
endmodule

// File: rtl/iss_pick.sv
module iss_pick
    import iss_pkg::*;
#(
    parameter int SEQ_W = 8
) (
    input  logic [NCLS-1:0]            elig,
    input  logic [NCLS-1:0][SEQ_W-1:0] seq,
    output logic                       any,
    output logic [2:0]                 idx
);
    logic [SEQ_W-1:0] best;

    // Strict compare in ascending class order keeps the lower class on ties.
    always_comb begin
        any  = 1'b0;
        idx  = 3'd0;
        best = '0;
        for (int c = 0; c < NCLS; c++) begin
            if (elig[c] && (!any || seq[c] < best)) begin
                any  = 1'b1;
                idx  = 3'(c);
                best = seq[c];
            end
        end
    end
endmodule

// File: rtl/issue_age_arbiter.sv
module issue_age_arbiter
    import iss_pkg::*;
#(
    parameter int ISSUE_W = 4,
    parameter int INT_CAP = 2,
    parameter int FP_CAP  = 1,
    parameter int BR_CAP  = 1,
    parameter int MEM_CAP = 2,
    parameter int SEQ_W   = 8,
    parameter int TAG_W   = 8
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          start_i,
    input  logic [5:0]                                    head_vld_i,
    input  logic [5:0][SEQ_W-1:0]                         head_seq_i,
    input  logic [5:0]                                    head_sq_i,
    input  logic [5:0][TAG_W-1:0]                         head_tag_i,
    output logic [5:0]                                    pop_o,
    output logic                                          busy_o,
    output logic                                          done_o,
    output logic [ISSUE_W-1:0][TAG_W-1:0]                 bundle_tag_o,
    output logic [ISSUE_W-1:0][2:0]                       bundle_cls_o,
    output logic [$clog2(ISSUE_W+1)-1:0]                  bundle_cnt_o,
    output logic [5:0][$clog2(ISSUE_W+1)-1:0]             cls_cnt_o,
    output logic [$clog2(ISSUE_W+1)-1:0]                  freed_o
);
    localparam int CNT_W = $clog2(ISSUE_W + 1);
    localparam logic [NCLS-1:0] DROP_MASK = NCLS'((1 << (NCLS - 1)) - 1);

    st_e st_q, st_d;
    logic [NCLS-1:0][CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0]           tot_q;
    logic [ISSUE_W-1:0][TAG_W-1:0] tag_q;
    logic [ISSUE_W-1:0][2:0]    cls_q;

    logic [NCLS-1:0] elig, drop;
    logic            any_win, do_drop, do_issue;
    logic [2:0]      win_idx, drop_idx;

    iss_elig #(
        .ISSUE_W(ISSUE_W), .INT_CAP(INT_CAP), .FP_CAP(FP_CAP),
        .BR_CAP(BR_CAP), .MEM_CAP(MEM_CAP), .CNT_W(CNT_W)
    ) u_elig (
        .vld  (head_vld_i),
        .cnt  (cnt_q),
        .elig (elig)
    );

    iss_pick #(.SEQ_W(SEQ_W)) u_pick (
        .elig (elig),
        .seq  (head_seq_i),
        .any  (any_win),
        .idx  (win_idx)
    );

    assign drop = elig & head_sq_i & DROP_MASK;

    always_comb begin
        drop_idx = 3'd0;
        for (int c = NCLS - 1; c >= 0; c--) begin
            if (drop[c]) drop_idx = 3'(c);
        end
    end

    // Next state and pop decisions.
    always_comb begin
        st_d     = st_q;
        pop_o    = '0;
        do_drop  = 1'b0;
        do_issue = 1'b0;
        unique case (st_q)
            S_IDLE: if (start_i) st_d = S_PICK;
            S_PICK: begin
                if (|drop) begin
                    do_drop         = 1'b1;
                    pop_o[drop_idx] = 1'b1;
                end else if (any_win) begin
                    do_issue       = 1'b1;
                    pop_o[win_idx] = 1'b1;
                    if (tot_q == CNT_W'(ISSUE_W - 1)) st_d = S_DONE;
                end else begin
                    st_d = S_DONE;
                end
            end
            S_DONE:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Bundle and count registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tot_q <= '0;
            tag_q <= '0;
            cls_q <= '0;
        end else if (st_q == S_IDLE && start_i) begin
            cnt_q <= '0;
            tot_q <= '0;
            tag_q <= '0;
            cls_q <= '0;
        end else if (do_issue) begin
            for (int s = 0; s < ISSUE_W; s++) begin
                if (tot_q == CNT_W'(s)) begin
                    tag_q[s] <= head_tag_i[win_idx];
                    cls_q[s] <= win_idx;
                end
            end
            cnt_q[win_idx] <= cnt_q[win_idx] + 1'b1;
            tot_q          <= tot_q + 1'b1;
        end
    end

    assign busy_o       = (st_q != S_IDLE);
    assign done_o       = (st_q == S_DONE);
    assign bundle_tag_o = tag_q;
    assign bundle_cls_o = cls_q;
    assign bundle_cnt_o = tot_q;
    assign cls_cnt_o    = cnt_q;
    assign freed_o      = tot_q;
endmodule

// File: rtl/iss_arb_chk.sv
module iss_arb_chk #(
    parameter int ISSUE_W = 4,
    parameter int INT_CAP = 2,
    parameter int FP_CAP  = 1,
    parameter int BR_CAP  = 1,
    parameter int MEM_CAP = 2,
    parameter int CNT_W   = $clog2(ISSUE_W + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [5:0]            pop_o,
    input logic [5:0]            head_vld_i,
    input logic                  busy_o,
    input logic                  done_o,
    input logic [CNT_W-1:0]      bundle_cnt_o,
    input logic [5:0][CNT_W-1:0] cls_cnt_o
);
    p_one_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_o));
    p_pop_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_o & ~head_vld_i) == 6'b0);
    p_pop_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_o != 6'b0) |-> busy_o);
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    p_total_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bundle_cnt_o <= CNT_W'(ISSUE_W));
    p_class_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_cnt_o[0] <= CNT_W'(INT_CAP)) && (cls_cnt_o[1] <= CNT_W'(FP_CAP)) &&
        (cls_cnt_o[2] <= CNT_W'(BR_CAP))  && (cls_cnt_o[3] <= CNT_W'(MEM_CAP)));
    p_full_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && bundle_cnt_o == CNT_W'(ISSUE_W)) |-> (pop_o == 6'b0));
endmodule

bind issue_age_arbiter iss_arb_chk #(
    .ISSUE_W(ISSUE_W), .INT_CAP(INT_CAP), .FP_CAP(FP_CAP),
    .BR_CAP(BR_CAP), .MEM_CAP(MEM_CAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pop_o(pop_o), .head_vld_i(head_vld_i),
    .busy_o(busy_o), .done_o(done_o), .bundle_cnt_o(bundle_cnt_o),
    .cls_cnt_o(cls_cnt_o)
);

// File: tb/issue_age_arbiter_tb.sv
`timescale 1ns/1ps
module issue_age_arbiter_tb;
    localparam int W = 4, NC = 6, DEPTH = 8, CW = 3;
    localparam int CAPS [NC] = '{2, 1, 1, 2, 4, 4};

    logic clk = 0, rst_n = 0, start_i = 0;
    logic [5:0] head_vld, head_sq, pop;
    logic [5:0][7:0] head_seq, head_tag;
    logic busy, done;
    logic [W-1:0][7:0] b_tag;
    logic [W-1:0][2:0] b_cls;
    logic [CW-1:0] b_cnt, freed;
    logic [5:0][CW-1:0] cc;

    always #2.5 clk = ~clk;

    issue_age_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .head_vld_i(head_vld), .head_seq_i(head_seq), .head_sq_i(head_sq),
        .head_tag_i(head_tag), .pop_o(pop), .busy_o(busy), .done_o(done),
        .bundle_tag_o(b_tag), .bundle_cls_o(b_cls), .bundle_cnt_o(b_cnt),
        .cls_cnt_o(cc), .freed_o(freed)
    );

    logic [7:0] q_seq [NC][DEPTH];
    logic       q_sq  [NC][DEPTH];
    logic [7:0] q_tag [NC][DEPTH];
    int q_len [NC];
    int q_rd  [NC];

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            head_vld[c] = q_rd[c] < q_len[c];
            head_seq[c] = q_seq[c][q_rd[c] % DEPTH];
            head_sq[c]  = q_sq[c][q_rd[c] % DEPTH];
            head_tag[c] = q_tag[c][q_rd[c] % DEPTH];
        end
    end

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_q();
        for (int c = 0; c < NC; c++) begin
            q_len[c] = 0; q_rd[c] = 0;
            for (int i = 0; i < DEPTH; i++) begin
                q_seq[c][i] = 8'hff; q_sq[c][i] = 0; q_tag[c][i] = 0;
            end
        end
    endtask

    task automatic push(input int c, input int seq, input bit sq);
        q_seq[c][q_len[c]] = 8'(seq);
        q_sq[c][q_len[c]]  = sq;
        q_tag[c][q_len[c]] = 8'(c * 16 + q_len[c]);
        q_len[c]++;
    endtask

    // Reference: oldest eligible head, caps, drop of cancelled heads (R3-R8).
    int e_n, e_tag [W], e_cls [W], e_cc [NC], e_rd [NC];
    task automatic model();
        bit stop = 0;
        e_n = 0;
        for (int c = 0; c < NC; c++) begin e_cc[c] = 0; e_rd[c] = q_rd[c]; end
        for (int s = 0; s < W; s++) begin e_tag[s] = 0; e_cls[s] = 0; end
        while (!stop && e_n < W) begin
            bit el [NC];
            int dropc = -1, best = -1;
            for (int c = 0; c < NC; c++)
                el[c] = (e_rd[c] < q_len[c]) && (e_cc[c] < CAPS[c]);
            for (int c = NC - 2; c >= 0; c--)
                if (el[c] && q_sq[c][e_rd[c]]) dropc = c;
            if (dropc >= 0) begin
                e_rd[dropc]++;
            end else begin
                for (int c = 0; c < NC; c++)
                    if (el[c] && (best < 0 || q_seq[c][e_rd[c]] < q_seq[best][e_rd[best]]))
                        best = c;
                if (best < 0) stop = 1;
                else begin
                    e_tag[e_n] = q_tag[best][e_rd[best]];
                    e_cls[e_n] = best;
                    e_cc[best]++; e_rd[best]++; e_n++;
                end
            end
        end
    endtask

    task automatic run_and_check(input string req, input int hold);
        logic [5:0] pend = '0;
        int cyc = 0;
        bit multi = 0, ok_done = 0;
        model();
        @(negedge clk); start_i = 1;
        forever begin
            @(posedge clk); #1;
            for (int c = 0; c < NC; c++) if (pend[c]) q_rd[c]++;
            cyc++;
            if (cyc >= hold) start_i = 0;
            @(negedge clk);
            pend = pop;
            if ($countones(pop) > 1) multi = 1;
            if (done) begin ok_done = 1; break; end
            if (cyc > 60) break;
        end
        chk(ok_done, {req, " R2 round completes"}, ok_done, 1);
        chk(!multi, {req, " R9 single pop"}, multi, 0);
        chk(int'(b_cnt) == e_n, {req, " R6 bundle count"}, b_cnt, e_n);
        chk(int'(freed) == e_n, {req, " R8 freed"}, freed, e_n);
        for (int s = 0; s < W; s++) if (s < e_n) begin
            chk(int'(b_tag[s]) == e_tag[s], {req, " R3 slot tag"}, b_tag[s], e_tag[s]);
            chk(int'(b_cls[s]) == e_cls[s], {req, " R3 slot class"}, b_cls[s], e_cls[s]);
        end
        for (int c = 0; c < NC; c++) begin
            chk(int'(cc[c]) == e_cc[c], {req, " R8 class count"}, cc[c], e_cc[c]);
            chk(q_rd[c] == e_rd[c], {req, " R7 list position"}, q_rd[c], e_rd[c]);
        end
        @(negedge clk);
        chk(!busy && !done, {req, " R2 idle after done"}, busy, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && pop == 0, "R1 idle outputs", {busy, done, pop}, 0);
        chk(b_cnt == 0 && freed == 0 && cc == '0, "R1 zero counts", b_cnt, 0);
    endtask

    task automatic t_ages();
        clear_q();
        push(0, 5, 0); push(0, 9, 0); push(1, 3, 0); push(2, 7, 0);
        push(3, 1, 0); push(3, 4, 0); push(4, 8, 0);
        run_and_check("R3 ages", 1);
        chk(b_tag[0] == 8'h30 && b_tag[1] == 8'h10, "R3 oldest first", b_tag[0], 8'h30);
    endtask

    task automatic t_tie();
        clear_q();
        for (int c = 0; c < NC; c++) push(c, 10, 0);
        run_and_check("R4 tie", 1);
        chk(b_cls[0] == 0 && b_cls[3] == 3, "R4 class order", b_cls[3], 3);
    endtask

    task automatic t_caps();
        clear_q();
        for (int i = 0; i < 4; i++) push(0, i + 1, 0);
        push(2, 0, 0); push(2, 2, 0);
        run_and_check("R5 caps", 1);
        chk(cc[0] == 2 && cc[2] == 1, "R5 int and branch capped", cc[0], 2);
    endtask

    task automatic t_squash();
        clear_q();
        push(0, 2, 1); push(0, 6, 0); push(1, 1, 1); push(1, 9, 0);
        push(5, 3, 1); push(4, 20, 0);
        run_and_check("R7 squash", 1);
        chk(b_tag[0] == 8'h50, "R7 squashed list issues", b_tag[0], 8'h50);
    endtask

    task automatic t_misc_total();
        clear_q();
        for (int i = 0; i < 6; i++) push(4, 30 + i, 0);
        push(5, 40, 0);
        run_and_check("R6 total", 1);
        chk(b_cnt == 3'(W), "R6 misc bounded by total", b_cnt, W);
    endtask

    task automatic t_empty();
        clear_q();
        run_and_check("R8 empty", 1);
        chk(b_cnt == 0, "R8 nothing issued", b_cnt, 0);
    endtask

    task automatic t_hold();
        clear_q();
        push(0, 4, 0); push(0, 5, 0); push(3, 1, 0); push(1, 2, 0);
        run_and_check("R10 start held", 3);
    endtask

    initial begin
        clear_q();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ages();
        t_tie();
        t_caps();
        t_squash();
        t_misc_total();
        t_empty();
        t_hold();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #50000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule